// File: doc/BRIEF.md
# Local Bus Slave Burst Sequencer

This block is the slave end of a processor local bus for a single master. A request brings a 32-bit byte address, a read/write flag, a 4-bit size code and a byte-enable field. The block decodes the size code into one of three kinds of transfer: a single beat, a cache-line transfer, or a fixed-length burst. It then walks the data phase one beat at a time, driving a word address and a read or write strobe toward a simple user-side register or memory port. That port returns read data in the same cycle. Each beat is acknowledged, and the last beat also raises a done pulse. Size codes that are reserved or cannot be served get an error response, and the user port is not touched.

The request is a valid/ready stream and is accepted only while the sequencer is idle. Accepting a request ends the address phase, and the data phase starts on the next cycle. Write data enters as a valid/ready stream and read data leaves as one. A beat happens only in a cycle where the master offers write data or can take read data. A master that withholds `wd_valid` or `rd_ready` stalls the transfer with no loss and no extra beat.

Top module: `lbus_burst_seq`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1, and its data phase (or its error response) occupies the next cycle. Throughout the data phase `req_ready` is 0.
- R2: Size code 0000 is one beat. `usr_addr` is the request address with bits 1:0 cleared, and `usr_be` equals the request byte enables.
- R3: Size codes 0001, 0010 and 0011 are cache-line transfers of 4, 8 and 16 beats with a step of 4 bytes. The transfer starts at the requested word and wraps within the line, which is aligned to 16, 32 or 64 bytes. `usr_be` is all ones.
- R4: Size codes 1010, 1011, 1100 and 1101 are fixed bursts whose beats are 4, 8, 16 and 32 bytes wide. The beat count is the byte-enable field read as an unsigned number. The address starts at the request address with bits 1:0 cleared and rises linearly by the beat width. `usr_be` is all ones.
- R5: An error response is given for any of these requests: a size code not listed in R2 to R4 (0100 to 1001, 1110, 1111), a burst count of 0 or above 16, or a burst beat wider than the data bus. For such a request, `xfer_err` is 1 for exactly the cycle after acceptance. In that cycle both strobes and `beat_ack` stay 0, and the sequencer is idle on the following cycle.
- R6: During a write data phase, `wd_ready` is 1 and `usr_wr` follows `wd_valid`. `usr_wdata` equals `wd_data`, and a beat completes in each cycle where `wd_valid` is 1.
- R7: During a read data phase, `rd_valid` is 1 and `usr_rd` follows `rd_ready`. `rd_data` equals `usr_rdata` in the same cycle, and a beat completes in each cycle where `rd_ready` is 1.
- R8: In a data-phase cycle with no beat, both strobes and `beat_ack` are 0, and `usr_addr` holds its value into the next cycle.
- R9: `beat_ack` is 1 in the cycle of every completed beat. `xfer_done` is 1 only together with the last beat's acknowledge, and the sequencer is idle in the following cycle.
- R10: A synchronous active-high `rst` returns the sequencer to idle, with both strobes, `beat_ack`, `xfer_done` and `xfer_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | 32 | Request byte address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_size | input | 4 | Transfer size code |
| req_be | input | DATA_W/8 | Byte enables, or beat count for bursts |
| wd_valid | input | 1 | Write beat data offered |
| wd_ready | output | 1 | Write data phase active |
| wd_data | input | DATA_W | Write beat data |
| rd_valid | output | 1 | Read data phase active, `rd_data` valid |
| rd_ready | input | 1 | Master accepts a read beat |
| rd_data | output | DATA_W | Read beat data |
| beat_ack | output | 1 | A data beat completes this cycle |
| xfer_done | output | 1 | Last beat completes this cycle |
| xfer_err | output | 1 | Rejected request response |
| usr_addr | output | 32 | User-side word address |
| usr_be | output | DATA_W/8 | User-side byte enables |
| usr_wr | output | 1 | User-side write strobe |
| usr_rd | output | 1 | User-side read strobe |
| usr_wdata | output | DATA_W | User-side write data |
| usr_rdata | input | DATA_W | User-side read data, same cycle as `usr_rd` |

## Verification
The first beat, or the error flag, is due in the cycle right after the accepting edge. After that, one beat is due per cycle in which the master offers a handshake. Strobes, `beat_ack`, `xfer_done` and read data are combinational on that handshake. The bench therefore changes inputs on the falling edge and samples one time unit later, inside the same cycle. It expects idle one full cycle after the last beat or the error cycle, and during an inserted stall cycle it checks that the address from the previous cycle is still present.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_ERR} seq_state_t;

  typedef struct packed {
    logic        bad;
    logic        single;
    logic [4:0]  beats;
    logic [5:0]  step;
    logic [31:0] mask;
  } xfer_plan_t;
endpackage

// File: rtl/lbs_decode.sv
module lbs_decode
  import lbs_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic [3:0]      size,
  input  logic [BE_W-1:0] be,
  output xfer_plan_t      plan
);
  localparam int MAX_BEATS = 16;

  logic [4:0] line_words;
  logic [5:0] beat_bytes;
  int unsigned cnt;

  always_comb begin
    line_words = 5'd4 << (size[1:0] - 2'd1);
    beat_bytes = 6'd4 << (size[2:0] - 3'd2);
    cnt        = 32'(be);
    plan        = '0;
    plan.beats  = 5'd1;
    plan.step   = 6'd4;
    plan.mask   = '1;
    unique case (size)
      4'b0000: plan.single = 1'b1;
      4'b0001, 4'b0010, 4'b0011: begin
        plan.beats = line_words;
        plan.mask  = (32'(line_words) << 2) - 32'd1;
      end
      4'b1010, 4'b1011, 4'b1100, 4'b1101: begin
        plan.step = beat_bytes;
        if (cnt == 0 || cnt > MAX_BEATS || 32'(beat_bytes) > BE_W)
          plan.bad = 1'b1;
        else
          plan.beats = 5'(cnt);
      end
      default: plan.bad = 1'b1;
    endcase
  end

  // R4
  always_comb begin
    if (!plan.bad) beats_range_chk: assert (plan.beats >= 5'd1 && plan.beats <= 5'd16);
  end
endmodule

// File: rtl/lbs_addr_gen.sv
module lbs_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [5:0]        step,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] cur, mask_q, nxt;
  logic [5:0]        step_q;

  assign nxt      = (cur & ~mask_q) | ((cur + ADDR_W'(step_q)) & mask_q);
  assign cur_addr = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      mask_q <= '1;
      step_q <= 6'd4;
    end else if (load) begin
      cur    <= start_addr;
      mask_q <= mask;
      step_q <= step;
    end else if (adv) begin
      cur <= nxt;
    end
  end

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(cur));
  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> ((cur & ~mask_q) == $past(cur & ~mask_q)));
endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_rnw,
  input  logic [BE_W-1:0] req_be,
  input  logic            plan_bad,
  input  logic            plan_single,
  input  logic [4:0]      plan_beats,
  input  logic            wd_valid,
  input  logic            rd_ready,
  output logic            req_ready,
  output logic            load,
  output logic            fire,
  output logic            last,
  output logic            in_data,
  output logic            rnw_q,
  output logic            single_q,
  output logic [BE_W-1:0] be_q,
  output logic            err
);
  seq_state_t state;
  logic [4:0] rem;

  assign req_ready = (state == ST_IDLE);
  assign load      = req_valid && req_ready;
  assign in_data   = (state == ST_DATA);
  assign fire      = in_data && (rnw_q ? rd_ready : wd_valid);
  assign last      = (rem == 5'd0);
  assign err       = (state == ST_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rem      <= '0;
      rnw_q    <= 1'b0;
      single_q <= 1'b0;
      be_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load) begin
          state    <= plan_bad ? ST_ERR : ST_DATA;
          rem      <= plan_beats - 5'd1;
          rnw_q    <= req_rnw;
          single_q <= plan_single;
          be_q     <= req_be;
        end
        ST_DATA: if (fire) begin
          if (last) state <= ST_IDLE;
          else      rem   <= rem - 5'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && last) |=> req_ready);
  // R5
  err_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> (req_ready && !err));
  // R1
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !req_ready);
endmodule

// File: rtl/lbus_burst_seq.sv
module lbus_burst_seq
  import lbs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_rnw,
  input  logic [3:0]        req_size,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              beat_ack,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic [31:0]       usr_addr,
  output logic [DATA_W/8-1:0] usr_be,
  output logic              usr_wr,
  output logic              usr_rd,
  output logic [DATA_W-1:0] usr_wdata,
  input  logic [DATA_W-1:0] usr_rdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int ADDR_W = 32;

  xfer_plan_t      plan;
  logic            load, fire, last, in_data, rnw_q, single_q;
  logic [BE_W-1:0] be_q;

  lbs_decode #(.BE_W(BE_W)) u_dec (
    .size(req_size), .be(req_be), .plan(plan)
  );

  lbs_ctrl #(.BE_W(BE_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rnw(req_rnw),
    .req_be(req_be), .plan_bad(plan.bad), .plan_single(plan.single),
    .plan_beats(plan.beats), .wd_valid(wd_valid), .rd_ready(rd_ready),
    .req_ready(req_ready), .load(load), .fire(fire), .last(last),
    .in_data(in_data), .rnw_q(rnw_q), .single_q(single_q), .be_q(be_q),
    .err(xfer_err)
  );

  lbs_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst(rst), .load(load), .adv(fire),
    .start_addr(req_addr & ~32'd3), .step(plan.step), .mask(plan.mask),
    .cur_addr(usr_addr)
  );

  assign wd_ready  = in_data && !rnw_q;
  assign rd_valid  = in_data && rnw_q;
  assign usr_wr    = wd_ready && wd_valid;
  assign usr_rd    = rd_valid && rd_ready;
  assign usr_wdata = wd_data;
  assign rd_data   = usr_rdata;
  assign usr_be    = single_q ? be_q : '1;
  assign beat_ack  = fire;
  assign xfer_done = fire && last;

  // R5
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_err |-> !(usr_wr || usr_rd || beat_ack));
  // R8
  stall_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !beat_ack |-> !(usr_wr || usr_rd));
  // R9
  done_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> beat_ack);
endmodule

// File: tb/lbus_burst_seq_bench.sv
module lbus_burst_seq_bench;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;
  localparam int NV    = 12;

  typedef struct packed {
    logic [3:0]  size;
    logic        rnw;
    logic [31:0] addr;
    logic [3:0]  be;
    logic        err;
    logic [4:0]  beats;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'h0, 1'b0, 32'h0000_1003, 4'h6, 1'b0, 5'd1},
    '{4'h0, 1'b1, 32'h0000_2000, 4'hF, 1'b0, 5'd1},
    '{4'h1, 1'b0, 32'h0000_0108, 4'hF, 1'b0, 5'd4},
    '{4'h2, 1'b1, 32'h0000_021C, 4'hF, 1'b0, 5'd8},
    '{4'h3, 1'b0, 32'h0000_0400, 4'hF, 1'b0, 5'd16},
    '{4'hA, 1'b0, 32'h0000_3002, 4'd5, 1'b0, 5'd5},
    '{4'hA, 1'b1, 32'h0000_0010, 4'd15, 1'b0, 5'd15},
    '{4'hB, 1'b0, 32'h0000_0000, 4'd2, 1'b1, 5'd0},
    '{4'hA, 1'b1, 32'h0000_0000, 4'd0, 1'b1, 5'd0},
    '{4'h5, 1'b0, 32'h0000_0000, 4'hF, 1'b1, 5'd0},
    '{4'hF, 1'b1, 32'h0000_0000, 4'hF, 1'b1, 5'd0},
    '{4'h8, 1'b0, 32'h0000_0000, 4'hF, 1'b1, 5'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_rnw = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic [BW-1:0] req_be = '0;
  logic wd_valid = 1'b0, wd_ready, rd_valid, rd_ready = 1'b0;
  logic [DW-1:0] wd_data = '0, rd_data, usr_wdata, usr_rdata;
  logic beat_ack, xfer_done, xfer_err, usr_wr, usr_rd;
  logic [31:0] usr_addr;
  logic [BW-1:0] usr_be;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;
  assign usr_rdata = ~usr_addr;

  lbus_burst_seq #(.DATA_W(DW)) u_lbus_burst_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rnw(req_rnw), .req_size(req_size), .req_be(req_be),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .beat_ack(beat_ack), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .usr_addr(usr_addr), .usr_be(usr_be), .usr_wr(usr_wr), .usr_rd(usr_rd),
    .usr_wdata(usr_wdata), .usr_rdata(usr_rdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(input vec_t v, input int k);
    int unsigned n, base, step;
    if (v.size == 4'h0) return v.addr & ~32'd3;
    if (v.size <= 4'h3) begin
      n    = 4 << (v.size - 1);
      base = v.addr & ~(n * 4 - 1);
      return base + (((v.addr >> 2) + k) % n) * 4;
    end
    step = 4 << (v.size - 4'hA);
    return (v.addr & ~32'd3) + k * step;
  endfunction

  task automatic issue(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_size = v.size; req_rnw = v.rnw;
    req_addr = v.addr; req_be = v.be;
    #1 chk(req_ready == 1'b1, "R1 ready in idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(input vec_t v);
    logic [BW-1:0] ebe;
    issue(v);
    if (v.err) begin
      #1;
      chk(xfer_err == 1'b1, "R5 error flag", 32'(xfer_err), 32'd1);
      chk(!usr_wr && !usr_rd && !beat_ack, "R5 no access", {29'd0, usr_wr, usr_rd, beat_ack}, 32'd0);
      @(negedge clk);
      #1;
      chk(req_ready && !xfer_err, "R5 back to idle", {30'd0, req_ready, xfer_err}, 32'd2);
      return;
    end
    ebe = (v.size == 4'h0) ? v.be : '1;
    for (int k = 0; k < int'(v.beats); k++) begin
      if (k == 1) begin
        #1;
        chk(!beat_ack && !usr_wr && !usr_rd, "R8 stall no strobe", {29'd0, beat_ack, usr_wr, usr_rd}, 32'd0);
        chk(usr_addr == exp_addr(v, k), "R8 stall address", usr_addr, exp_addr(v, k));
        @(negedge clk);
      end
      if (v.rnw) rd_ready = 1'b1;
      else begin wd_valid = 1'b1; wd_data = 32'hA500_0000 | k; end
      #1;
      chk(req_ready == 1'b0, "R1 busy in data", 32'(req_ready), 32'd0);
      chk(usr_addr == exp_addr(v, k), v.size == 0 ? "R2 address" : (v.size <= 3 ? "R3 wrap address" : "R4 burst address"),
          usr_addr, exp_addr(v, k));
      chk(usr_be == ebe, "R2 R3 R4 byte enables", 32'(usr_be), 32'(ebe));
      chk(beat_ack == 1'b1, "R9 beat ack", 32'(beat_ack), 32'd1);
      chk(xfer_done == (k == int'(v.beats) - 1), "R9 done on last", 32'(xfer_done), 32'(k == int'(v.beats) - 1));
      if (v.rnw) begin
        chk(usr_rd && !usr_wr && rd_valid, "R7 read strobe", {29'd0, usr_rd, usr_wr, rd_valid}, 32'd5);
        chk(rd_data == ~usr_addr, "R7 read data", rd_data, ~usr_addr);
      end else begin
        chk(usr_wr && !usr_rd && wd_ready, "R6 write strobe", {29'd0, usr_wr, usr_rd, wd_ready}, 32'd5);
        chk(usr_wdata == (32'hA500_0000 | k), "R6 write data", usr_wdata, 32'hA500_0000 | k);
      end
      @(negedge clk);
      rd_ready = 1'b0; wd_valid = 1'b0;
    end
    #1;
    chk(req_ready == 1'b1 && !xfer_done, "R9 idle after done", {30'd0, req_ready, xfer_done}, 32'd2);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !usr_wr && !usr_rd && !beat_ack && !xfer_err,
        "R10 reset state", {27'd0, req_ready, usr_wr, usr_rd, beat_ack, xfer_err}, 32'd16);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R10: reset in the middle of a cache-line write
    issue(VECS[4]);
    wd_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready && !usr_wr && !beat_ack && !xfer_done, "R10 reset mid transfer",
        {28'd0, req_ready, usr_wr, beat_ack, xfer_done}, 32'd8);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!usr_wr && req_ready, "R10 idle ignores write data", {30'd0, usr_wr, req_ready}, 32'd1);
    wd_valid = 1'b0;
    run(VECS[2]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule